// File: doc/BRIEF.md
# Host Port Word-to-Byte DMA Transmit Path

This block carries 24-bit words from a DSP core to a byte-wide host bus. The core writes a word into a transmit holding register. When the host-side receive bytes are free, the block copies the word into three receive byte slots (high, middle, low) and raises a data-ready flag. A host control register picks a transfer width and direction and carries a self-clearing initialise bit. When the receive request enable is set, the data-ready flag drives an active-low request pin that an external DMA controller answers with byte reads.

In DMA mode each acknowledge from the DMA controller returns the next byte of the selected width. Acknowledges run from the most significant byte in use down to the low byte. The acknowledge of the low byte empties the receive side, and a word waiting in the holding register moves across on the following cycle. While DMA mode is active, host reads of the receive byte addresses return zero and have no side effect. The control and status registers stay readable. On the core side, a transmit interrupt request is raised whenever its enable is set and the holding register is empty.

Top module: `hostport_dma_tx`

## Requirements
- R1: After reset the request pin is high, the control register (address 0) and the status register (address 1) read 0x00, and the transmit holding register is empty.
- R2: The control byte at address 0 holds the receive request enable in bit 0, the transmit request enable in bit 1, the mode in bits 3:2 and the initialise bit in bit 7. The initialise bit reads back as 1 for exactly one cycle after the write and as 0 afterwards.
- R3: The transmit interrupt output equals the transmit enable input ANDed with the holding-register-empty state, with no clock delay.
- R4: A core write that finds the holding register empty fills it. One cycle later, if the receive side is empty, the word moves to the receive bytes, status bit 0 (data ready) sets, and the holding register is empty again.
- R5: With the receive request enable set, the request pin goes low on the same clock edge that sets data ready. The pin is never low while data ready is clear.
- R6: The mode encoding is 01 = 24-bit, 10 = 16-bit and 11 = 8-bit. In these modes, DMA acknowledges return the bytes high, middle, low; middle, low; and low only.
- R7: The acknowledge of the low byte clears data ready and drives the request pin high on that edge. A word waiting in the holding register is moved across on the next edge.
- R8: While the mode is not 00, host reads of addresses 5 to 7 return 0x00 and do not clear data ready. The status register still reads back data ready.
- R9: In mode 00, addresses 5, 6 and 7 read the high, middle and low receive bytes, and a host read of address 7 clears data ready.
- R10: Writing the control register with the initialise bit set clears data ready, marks the holding register empty and discards any waiting word, one clock after the write.
- R11: Writing 0x00 to the control register (mode 00, both request enables clear) drives the request pin high on the following edge.
- R12: A core write while the holding register is full is ignored.
- R13: A DMA acknowledge while data ready is clear returns 0x00 and does not advance the byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dsp_wr | input | 1 | Core write strobe for the transmit holding register |
| dsp_wdata | input | 24 | Core write data |
| dsp_txie | input | 1 | Transmit interrupt enable |
| dsp_tx_irq | output | 1 | Transmit interrupt request |
| host_addr | input | 3 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host or DMA read data (combinational) |
| dma_ack | input | 1 | DMA acknowledge, one byte read per cycle |
| host_req_n | output | 1 | Active-low host request |

## Verification
The hardest state to reach from the ports is a full holding register behind a full receive side: a word waiting while the DMA controller drains the previous one. That state is what exposes the hand-off on the cycle after the last byte, and what makes the initialise bit's discard visible. The stimulus reaches it by issuing core writes back to back after the first word has landed, including a third write that must be ignored. It then checks that exactly the second word appears after the drain. Random words and random widths are mixed in, so that the byte order is exercised under each mode switch.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 3;
    localparam int WORD_W    = BYTE_W * NUM_BYTES;
    localparam int ADDR_W    = 3;
    localparam int IDX_W     = $clog2(NUM_BYTES);

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_RX0  = 3'd5;
    localparam logic [ADDR_W-1:0] A_RXLO = A_RX0 + ADDR_W'(NUM_BYTES - 1);

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_W24 = 2'b01,
        MODE_W16 = 2'b10,
        MODE_W8  = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        logic       init;
        xfer_mode_e mode;
        logic       treq;
        logic       rreq;
    } ctrl_t;

    function automatic logic is_dma(input xfer_mode_e m);
        return m != MODE_OFF;
    endfunction

    // Index of the first byte served in a DMA burst (0 = high byte).
    function automatic logic [IDX_W-1:0] first_idx(input xfer_mode_e m);
        case (m)
            MODE_W24: return IDX_W'(NUM_BYTES - 3);
            MODE_W16: return IDX_W'(NUM_BYTES - 2);
            default:  return IDX_W'(NUM_BYTES - 1);
        endcase
    endfunction

    function automatic ctrl_t decode_ctrl(input logic [BYTE_W-1:0] d);
        ctrl_t c;
        c.init = d[7];
        c.mode = xfer_mode_e'(d[3:2]);
        c.treq = d[1];
        c.rreq = d[0];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] encode_ctrl(input ctrl_t c);
        return {c.init, 3'b000, c.mode, c.treq, c.rreq};
    endfunction
endpackage

// File: rtl/hp_ctrl.sv
module hp_ctrl
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output ctrl_t             ctrl,
    output logic              ctrl_wr
);
    assign ctrl_wr = host_wr && (host_addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= decode_ctrl(host_wdata);
        end else begin
            ctrl.init <= 1'b0;
        end
    end
endmodule

// File: rtl/hp_xfer.sv
module hp_xfer
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dsp_wr,
    input  logic [WORD_W-1:0] dsp_wdata,
    input  logic              init,
    input  logic              rreq,
    input  logic              drain,
    output logic              tx_empty,
    output logic              rxdf,
    output logic [WORD_W-1:0] rx_word,
    output logic              req_q
);
    logic [WORD_W-1:0] hold;
    logic rxdf_d, txe_d, load_hold, move;

    always_comb begin
        rxdf_d    = rxdf;
        txe_d     = tx_empty;
        load_hold = 1'b0;
        move      = 1'b0;
        if (init) begin
            rxdf_d = 1'b0;
            txe_d  = 1'b1;
        end else begin
            if (drain) rxdf_d = 1'b0;
            if (!tx_empty && !rxdf) begin
                move   = 1'b1;
                rxdf_d = 1'b1;
                txe_d  = 1'b1;
            end else if (dsp_wr && tx_empty) begin
                load_hold = 1'b1;
                txe_d     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxdf     <= 1'b0;
            tx_empty <= 1'b1;
            hold     <= '0;
            rx_word  <= '0;
            req_q    <= 1'b0;
        end else begin
            rxdf     <= rxdf_d;
            tx_empty <= txe_d;
            req_q    <= rreq && rxdf_d;
            if (load_hold) hold <= dsp_wdata;
            if (move)      rx_word <= hold;
        end
    end
endmodule

// File: rtl/hp_seq.sv
module hp_seq
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic              ctrl_wr,
    input  logic              dma_ack,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              rxdf,
    input  logic [WORD_W-1:0] rx_word,
    output logic [BYTE_W-1:0] rdata,
    output logic              drain
);
    logic [BYTE_W-1:0] rx_b [NUM_BYTES];
    logic [IDX_W-1:0]  cnt, idx;
    logic [ADDR_W-1:0] off;
    logic dma, ack_ok, last;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_bytes
        assign rx_b[g] = rx_word[WORD_W-1-g*BYTE_W -: BYTE_W];
    end

    assign dma    = is_dma(ctrl.mode);
    assign idx    = first_idx(ctrl.mode) + cnt;
    assign last   = (idx == IDX_W'(NUM_BYTES - 1));
    assign ack_ok = dma_ack && dma && rxdf;
    assign off    = host_addr - A_RX0;
    assign drain  = (ack_ok && last) ||
                    (!dma && !dma_ack && host_rd && rxdf && host_addr == A_RXLO);

    always_ff @(posedge clk) begin
        if (rst || ctrl_wr || ctrl.init) begin
            cnt <= '0;
        end else if (ack_ok) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (dma_ack) begin
            if (dma && rxdf) rdata = rx_b[idx];
        end else if (host_rd) begin
            if (host_addr == A_CTRL) begin
                rdata = encode_ctrl(ctrl);
            end else if (host_addr == A_STAT) begin
                rdata = {{(BYTE_W-1){1'b0}}, rxdf};
            end else if (host_addr >= A_RX0 && off < ADDR_W'(NUM_BYTES) && !dma) begin
                rdata = rx_b[off[IDX_W-1:0]];
            end
        end
    end
endmodule

// File: rtl/hostport_dma_tx.sv
module hostport_dma_tx
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dsp_wr,
    input  logic [WORD_W-1:0] dsp_wdata,
    input  logic              dsp_txie,
    output logic              dsp_tx_irq,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              dma_ack,
    output logic              host_req_n
);
    ctrl_t             ctrl;
    logic              ctrl_wr, tx_empty, rxdf, req_q, drain;
    logic [WORD_W-1:0] rx_word;

    hp_ctrl u_ctrl (
        .clk, .rst, .host_wr, .host_addr, .host_wdata,
        .ctrl, .ctrl_wr
    );

    hp_xfer u_xfer (
        .clk, .rst, .dsp_wr, .dsp_wdata,
        .init(ctrl.init), .rreq(ctrl.rreq), .drain,
        .tx_empty, .rxdf, .rx_word, .req_q
    );

    hp_seq u_seq (
        .clk, .rst, .ctrl, .ctrl_wr, .dma_ack, .host_rd, .host_addr,
        .rxdf, .rx_word, .rdata(host_rdata), .drain
    );

    assign dsp_tx_irq = dsp_txie && tx_empty;
    assign host_req_n = !req_q;
endmodule

// File: rtl/hp_checker.sv
module hp_checker
    import hp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              dsp_wr,
    input logic              host_wr,
    input logic              host_rd,
    input logic              dma_ack,
    input logic [ADDR_W-1:0] host_addr,
    input logic [BYTE_W-1:0] host_wdata,
    input logic [BYTE_W-1:0] host_rdata,
    input logic              host_req_n,
    input ctrl_t             ctrl,
    input logic              tx_empty,
    input logic              rxdf,
    input logic              drain
);
    a_r5_req_needs_data: assert property (@(posedge clk) disable iff (rst)
        !host_req_n |-> rxdf);

    a_r4_write_fills: assert property (@(posedge clk) disable iff (rst)
        (dsp_wr && tx_empty && !ctrl.init) |=> !tx_empty);

    a_r2_init_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (ctrl.init && !(host_wr && host_addr == A_CTRL && host_wdata[7])) |=> !ctrl.init);

    a_r10_init_flags: assert property (@(posedge clk) disable iff (rst)
        ctrl.init |=> (!rxdf && tx_empty));

    a_r7_drain_releases: assert property (@(posedge clk) disable iff (rst)
        drain |=> (host_req_n && !rxdf));

    a_r8_rx_locked: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode != MODE_OFF && host_rd && !dma_ack && host_addr >= A_RX0)
        |-> host_rdata == '0);
endmodule

bind hostport_dma_tx hp_checker i_hp_checker (
    .clk, .rst, .dsp_wr, .host_wr, .host_rd, .dma_ack, .host_addr,
    .host_wdata, .host_rdata, .host_req_n,
    .ctrl, .tx_empty, .rxdf, .drain
);

// File: tb/test_hostport_dma_tx.sv
`timescale 1ns/1ps
module test_hostport_dma_tx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dsp_wr = 1'b0;
    logic [23:0] dsp_wdata = '0;
    logic        dsp_txie = 1'b0;
    logic        dsp_tx_irq;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        dma_ack = 1'b0;
    logic        host_req_n;

    int errors = 0;
    int total  = 0;

    always #10 clk = ~clk;

    hostport_dma_tx i_hostport_dma_tx (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input int mode);
        return (mode == 1) ? 3 : (mode == 2) ? 2 : 1;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [23:0] w, input int mode, input int k);
        int i;
        i = 3 - nbytes(mode) + k;
        return w[23-8*i -: 8];
    endfunction

    // All tasks start and end at a falling edge, spanning one rising edge.
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic dma_read(output logic [7:0] d);
        dma_ack = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    task automatic dsp_write(input logic [23:0] w);
        dsp_wdata = w; dsp_wr = 1'b1;
        @(negedge clk);
        dsp_wr = 1'b0;
    endtask

    task automatic drain_word(input string req, input logic [23:0] w, input int mode);
        logic [7:0] b;
        for (int k = 0; k < nbytes(mode); k++) begin
            dma_read(b);
            check(req, b, exp_byte(w, mode, k));
        end
        check({req, " req released"}, host_req_n, 1'b1);
    endtask

    initial begin
        #4_000_000;
        errors++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [23:0] w;
        int          mode;
        void'($urandom(32'h5eed_0042));

        idle(3);
        rst = 1'b0;

        // R1 reset state
        check("R1 req_n", host_req_n, 1'b1);
        check("R1 irq off", dsp_tx_irq, 1'b0);
        host_read(3'd0, b); check("R1 ctrl", b, 8'h00);
        host_read(3'd1, b); check("R1 status", b, 8'h00);

        // R3 immediate interrupt when empty
        dsp_txie = 1'b1; #1;
        check("R3 irq at once", dsp_tx_irq, 1'b1);
        idle(1);

        // R2 control layout and INIT pulse: mode 01, rreq, init
        host_write(3'd0, 8'h85);
        host_read(3'd0, b); check("R2 init visible", b, 8'h85);
        host_read(3'd0, b); check("R2 init cleared", b, 8'h05);

        // R4/R5/R3 first word, R8 lock, R6 order
        dsp_write(24'hA1B2C3);
        check("R3 irq off while full", dsp_tx_irq, 1'b0);
        check("R4 no data yet", host_req_n, 1'b1);
        idle(1);
        check("R5 req low", host_req_n, 1'b0);
        check("R4 holding empty again", dsp_tx_irq, 1'b1);
        host_read(3'd1, b); check("R8 status readable", b, 8'h01);
        host_read(3'd5, b); check("R8 rx high locked", b, 8'h00);
        host_read(3'd7, b); check("R8 rx low locked", b, 8'h00);
        check("R8 data kept", host_req_n, 1'b0);
        drain_word("R6 w24 order", 24'hA1B2C3, 1);

        // R7/R12 waiting word handoff and ignored write
        dsp_write(24'h112233);
        idle(1);
        dsp_write(24'h445566);
        dsp_write(24'h778899);
        drain_word("R7 first word", 24'h112233, 1);
        idle(1);
        check("R7 waiting word moved", host_req_n, 1'b0);
        drain_word("R12 second word kept", 24'h445566, 1);
        idle(2);
        check("R12 third write dropped", host_req_n, 1'b1);

        // R13 acknowledge with no data
        dma_read(b); check("R13 empty ack data", b, 8'h00);
        dsp_write(24'hDEAD01);
        idle(1);
        drain_word("R13 order not advanced", 24'hDEAD01, 1);

        // R6 random widths and words
        for (int it = 0; it < 40; it++) begin
            mode = 1 + ($urandom % 3);
            w = 24'($urandom);
            host_write(3'd0, 8'((mode << 2) | 1));
            dsp_write(w);
            idle(1);
            check("R5 random req low", host_req_n, 1'b0);
            drain_word("R6 random", w, mode);
        end

        // R11 leave DMA mode, then R9 plain reads
        host_write(3'd0, 8'h05);
        dsp_write(24'hC0FFEE);
        idle(1);
        check("R11 req low before exit", host_req_n, 1'b0);
        host_write(3'd0, 8'h00);
        idle(1);
        check("R11 req released", host_req_n, 1'b1);
        host_read(3'd5, b); check("R9 high byte", b, 8'hC0);
        host_read(3'd6, b); check("R9 middle byte", b, 8'hFF);
        host_read(3'd1, b); check("R9 still full", b, 8'h01);
        host_read(3'd7, b); check("R9 low byte", b, 8'hEE);
        host_read(3'd1, b); check("R9 low read empties", b, 8'h00);

        // R10 initialise discards both words
        host_write(3'd0, 8'h05);
        dsp_write(24'h123456);
        idle(1);
        dsp_write(24'h654321);
        check("R10 pending held", dsp_tx_irq, 1'b0);
        host_write(3'd0, 8'h85);
        idle(1);
        check("R10 req released", host_req_n, 1'b1);
        check("R10 holding empty", dsp_tx_irq, 1'b1);
        host_read(3'd1, b); check("R10 status clear", b, 8'h00);
        idle(3);
        check("R10 pending dropped", host_req_n, 1'b1);
        dsp_write(24'h0A0B0C);
        idle(1);
        drain_word("R10 fresh word", 24'h0A0B0C, 1);

        // R3 enable off
        dsp_txie = 1'b0; #1;
        check("R3 irq disabled", dsp_tx_irq, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end
endmodule